// File: doc/BRIEF.md
# Coprocessor Card Control and Status Register

This block is the control and status register of a coprocessor card that sits on a host bus. The register is 16 bits wide. Software changes it one bit at a time: every bit has its own write address, and the new value of that bit is taken from bit 0 of the write data. A read always returns the whole register, zero-extended to a 32-bit bus word.

Some bits are set and cleared only by software: cache off, the local-processor interrupt request, the host interrupt request, halt and card reset. Two sticky status bits are set by hardware, one for an alignment fault and one for a bus fault during a main-memory access, and software clears them. Halt is also forced on by a bus-side reset and by the card-reset bit. Two further addresses in the same window turn writes into one-cycle cache-flush strobes. The register drives the cache-disable, interrupt, halt and card-reset outputs directly.

Top module: `cop_ctl_reg`

## Requirements
- R1: Bits 15, 12 and 10 down to 4 are reserved. They always read as 0 and writes to their addresses have no effect. Read-data bits 31 to 16 are always 0.
- R2: A write with `wr_en_i` high to address BASE_ADDR + 4*n (n from 0 to 15) loads write-data bit 0 into register bit n on the next clock edge. Every other bit keeps its value.
- R3: A synchronous power-up reset (`rst_n` low at a clock edge) loads 16'h4002: bit 14 and bit 1 are 1, all other bits are 0. The flush strobes are 0.
- R4: `rd_data_o[15:0]` is the register. `cache_dis_o` is bit 14, `local_irq_o` is bit 13, `host_irq_o` is bit 2, `halt_o` is bit 1 and `card_rst_o` is bit 0.
- R5: A write to BASE_ADDR + 0x44 raises `flush_all_o`, and a write to BASE_ADDR + 0x48 raises `flush_data_o`. The strobe is high for exactly the clock cycle after the write edge. Neither write changes any register bit.
- R6: `align_fault_i` high at a clock edge sets bit 11. The bit stays 1 until software writes 0 to it.
- R7: `bus_fault_i` high together with `mem_access_i` at a clock edge sets bit 3, which stays 1 until software writes 0 to it. `bus_fault_i` without `mem_access_i` leaves bit 3 unchanged.
- R8: If a hardware set and a software write of 0 reach bit 11 or bit 3 at the same edge, the bit ends up 1.
- R9: `bus_rst_n` low at a clock edge clears bit 0 and sets bit 1. Both take priority over a software write in the same cycle. All other bits are unaffected.
- R10: While bit 0 is 1, bit 1 is set on the next edge, even when software writes 0 to bit 1 at that edge.
- R11: A write with `wr_en_i` low, a write to an address that is not word-aligned, or a write outside BASE_ADDR to BASE_ADDR + 0x3C (other than the two flush addresses) changes no bit and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| bus_rst_n | input | 1 | Synchronous active-low bus-side reset: clears card reset, sets halt |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_data_i | input | 32 | Write data; only bit 0 is used |
| align_fault_i | input | 1 | Alignment fault seen by the card processor |
| bus_fault_i | input | 1 | Fault reported on the host bus |
| mem_access_i | input | 1 | Card is accessing main memory in this cycle |
| rd_data_o | output | 32 | Register zero-extended to 32 bits |
| cache_dis_o | output | 1 | Cache disable |
| local_irq_o | output | 1 | Level-15 interrupt request to the card processor |
| host_irq_o | output | 1 | Level-15 interrupt request to the host processor |
| halt_o | output | 1 | Holds the card processor quiescent |
| card_rst_o | output | 1 | Card reset |
| flush_all_o | output | 1 | One-cycle full-cache flush strobe |
| flush_data_o | output | 1 | One-cycle data-section flush strobe |

## Verification
The case that matters most is a hardware set that lands in the same cycle as a software write of 0 to the same bit. The bench provokes it by raising the alignment-fault input, or the bus-fault and memory-access pair, in the very cycle it writes 0 to bit 11 or bit 3. The same collision is provoked on halt, first through a bus-side reset and then through a set card-reset bit. A behavioural model in the bench applies the stated priority, set before clear before write, and every output is compared with the model on every clock.

// File: rtl/ccr_pkg.sv
// Package: ccr_pkg
// Shared constants for the coprocessor control register: register width,
// bit positions, the reserved-bit mask, reset values and the offsets of
// the flush addresses. Assumes a 16-bit register read over a 32-bit bus.
package ccr_pkg;
    localparam int NBITS   = 16;
    localparam int RD_W    = 32;
    localparam int IDX_W   = $clog2(NBITS);

    localparam int B_CARD_RST  = 0;
    localparam int B_HALT      = 1;
    localparam int B_HOST_IRQ  = 2;
    localparam int B_BUS_ERR   = 3;
    localparam int B_ALIGN     = 11;
    localparam int B_LOCAL_IRQ = 13;
    localparam int B_CACHE_OFF = 14;

    // Bits 15, 12 and 10:4 hold no storage.
    localparam logic [NBITS-1:0] RSVD_MASK = 16'h97F0;
    // Power-up values: cache off and halt set.
    localparam logic [NBITS-1:0] RST_VALS  = 16'h4002;

    localparam int OFF_FLUSH_ALL  = 'h44;
    localparam int OFF_FLUSH_DATA = 'h48;
endpackage

// File: rtl/ccr_decode.sv
// Module: ccr_decode
// Turns one bus write into a one-hot bit-select vector and two flush hits.
// Assumes BASE_ADDR is word aligned, bit n sits at BASE_ADDR + 4*n, and
// the flush addresses lie outside the bit window.
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NBITS-1:0]  sel_o,
    output logic              hit_all_o,
    output logic              hit_data_o
);
    localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(NBITS * 4);
    localparam logic [ADDR_W-1:0] A_ALL     = BASE_ADDR + ADDR_W'(OFF_FLUSH_ALL);
    localparam logic [ADDR_W-1:0] A_DATA    = BASE_ADDR + ADDR_W'(OFF_FLUSH_DATA);

    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic [IDX_W-1:0]  idx;

    // Offset inside the window and whether it names a register bit.
    always_comb begin
        off    = addr_i - BASE_ADDR;
        in_win = (addr_i >= BASE_ADDR) && (off < WIN_BYTES) && (off[1:0] == 2'b00);
        idx    = off[IDX_W+1:2];
    end

    // One-hot select of the written bit, zero when no bit is addressed.
    always_comb begin
        sel_o = '0;
        if (wr_en_i && in_win)
            sel_o[idx] = 1'b1;
    end

    // Flush address matches.
    always_comb begin
        hit_all_o  = wr_en_i && (addr_i == A_ALL);
        hit_data_o = wr_en_i && (addr_i == A_DATA);
    end

    // R2: at most one bit is selected by any access.
    assert_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // R5: a flush hit never also selects a register bit.
    assert_flush_no_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_all_o || hit_data_o) |-> (sel_o == '0));
endmodule

// File: rtl/ccr_cell.sv
// Module: ccr_cell
// One storage bit of the register. Priority: power-up reset, hardware set,
// hardware clear, software write. Assumes set and clear are synchronous.
module ccr_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic wr_i,
    input  logic wd_i,
    output logic q_o
);
    // Bit update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= RST_VAL;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
        else if (wr_i)
            q_o <= wd_i;
    end

    // R8: a hardware set always lands, whatever software writes.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R2: with no request the bit holds.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i || clr_i || wr_i) |=> $stable(q_o));
endmodule

// File: rtl/ccr_pulse.sv
// Module: ccr_pulse
// Registers a decode hit into a strobe one clock wide.
// Assumes the hit is qualified with the write strobe already.
module ccr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic pulse_o
);
    // Strobe follows the hit by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_o <= 1'b0;
        else
            pulse_o <= hit_i;
    end

    // R5: a hit yields a strobe in the next cycle.
    assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> pulse_o);

    // R11: no hit, no strobe.
    assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> !pulse_o);
endmodule

// File: rtl/cop_ctl_reg.sv
// Module: cop_ctl_reg
// Top of the coprocessor control and status register. Decodes bit-wise
// writes, holds one cell per implemented bit, wires the hardware set and
// clear sources, and issues the two flush strobes.
// Assumes one access per cycle and synchronous fault inputs.
module cop_ctl_reg
    import ccr_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              align_fault_i,
    input  logic              bus_fault_i,
    input  logic              mem_access_i,
    output logic [31:0]       rd_data_o,
    output logic              cache_dis_o,
    output logic              local_irq_o,
    output logic              host_irq_o,
    output logic              halt_o,
    output logic              card_rst_o,
    output logic              flush_all_o,
    output logic              flush_data_o
);
    logic [NBITS-1:0] sel;
    logic [NBITS-1:0] set_v;
    logic [NBITS-1:0] clr_v;
    logic [NBITS-1:0] q;
    logic             hit_all;
    logic             hit_data;
    logic             wdata_unused;

    assign wdata_unused = ^wr_data_i[31:1];

    ccr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .sel_o      (sel),
        .hit_all_o  (hit_all),
        .hit_data_o (hit_data)
    );

    // Hardware set and clear sources per bit.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[B_ALIGN]    = align_fault_i;
        set_v[B_BUS_ERR]  = bus_fault_i && mem_access_i;
        set_v[B_HALT]     = !bus_rst_n || q[B_CARD_RST];
        clr_v[B_CARD_RST] = !bus_rst_n;
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (RSVD_MASK[i]) begin : g_rsvd
            logic rsvd_unused;
            assign rsvd_unused = sel[i] | set_v[i] | clr_v[i];
            assign q[i] = 1'b0;
        end else begin : g_cell
            ccr_cell #(.RST_VAL(RST_VALS[i])) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[i]),
                .clr_i (clr_v[i]),
                .wr_i  (sel[i]),
                .wd_i  (wr_data_i[0]),
                .q_o   (q[i])
            );
        end
    end

    ccr_pulse u_flush_all (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_all), .pulse_o(flush_all_o));
    ccr_pulse u_flush_data (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_data), .pulse_o(flush_data_o));

    // Read word and control outputs.
    always_comb begin
        rd_data_o   = {{(RD_W-NBITS){1'b0}}, q};
        cache_dis_o = q[B_CACHE_OFF];
        local_irq_o = q[B_LOCAL_IRQ];
        host_irq_o  = q[B_HOST_IRQ];
        halt_o      = q[B_HALT];
        card_rst_o  = q[B_CARD_RST];
    end

    // R9: a bus-side reset releases card reset and halts the card.
    assert_bus_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> (halt_o && !card_rst_o));

    // R10: card reset keeps the card halted on the following cycle.
    assert_rst_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_o |=> halt_o);

    // R6: an alignment fault shows on the read word next cycle.
    assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_i |=> rd_data_o[B_ALIGN]);

    // R7: a bus fault outside a memory access leaves the error bit alone
    // unless software writes it.
    assert_bus_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_access_i && !sel[B_BUS_ERR]) |=> $stable(rd_data_o[B_BUS_ERR]));
endmodule

// File: tb/cop_ctl_reg_tb.sv
// Bench for cop_ctl_reg: a behavioural model of the register is stepped
// on every clock and all outputs are compared against it one half-cycle
// after each edge.
module cop_ctl_reg_tb;
    localparam int          AW   = 20;
    localparam logic [19:0] BASE = 20'h10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        af = 1'b0;
    logic        bf = 1'b0;
    logic        ma = 1'b0;

    logic [31:0] rd_data;
    logic        cache_dis, local_irq, host_irq, halt, card_rst, fl_all, fl_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state.
    logic [15:0] m;
    logic        m_fa, m_fd;

    always #5 clk = ~clk;

    cop_ctl_reg #(.ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .align_fault_i(af),
        .bus_fault_i(bf), .mem_access_i(ma), .rd_data_o(rd_data),
        .cache_dis_o(cache_dis), .local_irq_o(local_irq), .host_irq_o(host_irq),
        .halt_o(halt), .card_rst_o(card_rst), .flush_all_o(fl_all),
        .flush_data_o(fl_data));

    // Advance the model by one edge using the inputs now driven.
    task automatic model_step();
        logic [15:0] nm;
        int          off;
        nm  = m;
        off = int'(addr) - int'(BASE);
        if (!rst_n) begin
            nm   = 16'h4002;
            m_fa = 1'b0;
            m_fd = 1'b0;
        end else begin
            m_fa = wr_en && (off == 'h44);
            m_fd = wr_en && (off == 'h48);
            if (wr_en && off >= 0 && off < 64 && (off % 4) == 0) begin
                int n = off / 4;
                if (!(n == 15 || n == 12 || (n >= 4 && n <= 10)))
                    nm[n] = wdata[0];
            end
            if (m[0]) nm[1] = 1'b1;
            if (!bus_rst_n) begin
                nm[0] = 1'b0;
                nm[1] = 1'b1;
            end
            if (af) nm[11] = 1'b1;
            if (bf && ma) nm[3] = 1'b1;
        end
        m = nm;
    endtask

    task automatic compare(input string tag);
        logic [38:0] act, exp;
        act = {rd_data, cache_dis, local_irq, host_irq, halt, card_rst, fl_all, fl_data};
        exp = {16'h0, m, m[14], m[13], m[2], m[1], m[0], m_fa, m_fd};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic write_bit(input int n, input logic v, input string tag);
        wr_en = 1'b1;
        addr  = BASE + 20'(4 * n);
        wdata = {31'h7FFF_FFFF, v};
        cycle(tag);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic write_addr(input logic [19:0] a, input logic v, input string tag);
        wr_en = 1'b1;
        addr  = a;
        wdata = {31'h0, v};
        cycle(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure and still reports.
        #500us;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle("R3 reset");
        cycle("R3 reset");
        rst_n = 1'b1;
        cycle("R3 after reset");

        // R2 / R4: every implemented bit set and cleared alone.
        for (int n = 0; n < 16; n++) write_bit(n, 1'b1, "R2 set bit");
        cycle("R4 outputs");
        for (int n = 15; n >= 0; n--) write_bit(n, 1'b0, "R2 clear bit");
        cycle("R10 halt after card reset");
        write_bit(1, 1'b0, "R2 clear halt");

        // R1: reserved bits ignore writes.
        write_bit(15, 1'b1, "R1 reserved 15");
        write_bit(12, 1'b1, "R1 reserved 12");
        write_bit(7, 1'b1, "R1 reserved 7");
        write_bit(13, 1'b1, "R4 local irq");
        write_bit(2, 1'b1, "R4 host irq");

        // R5: flush strobes, back to back and alone.
        write_addr(BASE + 20'h44, 1'b1, "R5 flush all");
        write_addr(BASE + 20'h48, 1'b1, "R5 flush data");
        write_addr(BASE + 20'h44, 1'b0, "R5 flush all again");
        cycle("R5 strobe ends");

        // R6 / R7: sticky faults.
        af = 1'b1; cycle("R6 align set"); af = 1'b0;
        cycle("R6 align sticky");
        write_bit(11, 1'b0, "R6 align cleared");
        bf = 1'b1; ma = 1'b0; cycle("R7 fault without access");
        ma = 1'b1; cycle("R7 fault with access"); bf = 1'b0; ma = 1'b0;
        cycle("R7 error sticky");
        write_bit(3, 1'b0, "R7 error cleared");

        // R8: hardware set against software clear in the same cycle.
        af = 1'b1; write_bit(11, 1'b0, "R8 align beats clear"); af = 1'b0;
        bf = 1'b1; ma = 1'b1; write_bit(3, 1'b0, "R8 error beats clear");
        bf = 1'b0; ma = 1'b0;

        // R10: card reset holds halt despite a software clear.
        write_bit(0, 1'b1, "R10 card reset on");
        write_bit(1, 1'b0, "R10 halt clear loses");
        cycle("R10 halt held");

        // R9: bus-side reset against software writes.
        bus_rst_n = 1'b0; write_bit(0, 1'b1, "R9 bus reset clears card reset");
        bus_rst_n = 1'b1;
        write_bit(1, 1'b0, "R9 halt released");
        bus_rst_n = 1'b0; write_bit(1, 1'b0, "R9 bus reset sets halt");
        bus_rst_n = 1'b1;
        cycle("R9 others kept");

        // R11: ignored accesses.
        wr_en = 1'b0; addr = BASE + 20'h8; wdata = 32'h0;
        cycle("R11 no enable");
        write_addr(BASE + 20'h9, 1'b0, "R11 misaligned");
        write_addr(BASE + 20'h40, 1'b1, "R11 gap address");
        write_addr(BASE - 20'h4, 1'b1, "R11 below base");
        write_addr(BASE + 20'h100, 1'b1, "R11 far above");
        write_addr(BASE + 20'h45, 1'b1, "R11 misaligned flush");
        cycle("R11 quiet");

        // R3: power-up reset mid-run.
        rst_n = 1'b0; cycle("R3 second reset");
        rst_n = 1'b1; cycle("R3 after second reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule